// File: doc/BRIEF.md
# Free Message-Frame Address Queue Manager

This block hands out free message-frame addresses (MFAs) to a host. The addresses are kept in a circular list in local shared memory. A local processor fills the list: it stores an MFA in memory at the queue base plus the head offset, then writes the new head offset into the block. The host pops one entry per read request. The block compares head and tail. If they are equal, the list is empty and the block answers with all-ones. If not, it reads the word at base plus tail over a single-outstanding local memory read port, returns that word and advances the tail.

An optional prefetch register, switched on by bit 3 of the control word, reads the next entry ahead of time whenever the list is non-empty. A later host pop is then answered one cycle after the request, with no memory access. Any software write to a pointer or to the base, any write that turns prefetch off, and an empty list all discard the prefetched word. This keeps a stale MFA from ever being handed out.

Top module: `mfq_freelist`

## Requirements
- R1: After a synchronous reset, head and tail offsets read 0, prefetch is off, `pop_ready` is low and `mem_req` is low.
- R2: A pop while head equals tail returns 32'hFFFFFFFF one cycle after the request. It leaves both offsets unchanged and makes no memory read.
- R3: A pop on a non-empty list with prefetch off reads memory at address base OR tail offset, returns the word read and advances the tail by 4.
- R4: Configuration writes use `cfg_sel` codes 0 = base, 1 = head, 2 = tail, 3 = control. Head and tail keep bits [OFF_W-1:2] of the written word, with the lower two bits forced to zero. Base keeps bits [ADDR_W-1:OFF_W].
- R5: An offset advance from 2^OFF_W - 4 wraps to 0.
- R6: With control bit 3 set, a pop that leaves the list non-empty is followed by one memory read of the next entry, without a host request.
- R7: A pop served from a valid prefetch register completes one cycle after the request, makes no memory read and advances the tail by 4.
- R8: A software write to head, tail or base, or a control write with bit 3 clear, discards the prefetched word. It also discards any prefetch still in flight. The next pop then returns the current memory contents.
- R9: A head write that makes an empty list non-empty while prefetch is on starts a prefetch of the new entry.
- R10: At most one memory read is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_rvalid`.
- R11: `pop_ready` is a single-cycle pulse carrying the result on `pop_data`. The host holds `pop_valid` until it sees that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 head, 2 tail, 3 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| head_ptr | output | OFF_W | Current head offset |
| tail_ptr | output | OFF_W | Current tail offset |
| pop_valid | input | 1 | Host pop request, held until `pop_ready` |
| pop_ready | output | 1 | One-cycle pop completion |
| pop_data | output | 32 | Popped MFA, or all-ones when the list was empty |
| mem_req | output | 1 | Local memory read request |
| mem_addr | output | ADDR_W | Local memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest case to reach is a prefetched or in-flight word that has gone stale behind the block's back. Looking only at the returned value, the stale word and the fresh word are identical unless the memory slot changes. The stimulus therefore waits until a prefetch has landed, rewrites the memory word behind it, and then issues a pointer write or turns prefetch off. Returning the new word, together with the change in the memory-read count and in the pop latency, shows whether the old one was discarded.

// File: rtl/mfq_pkg.sv
package mfq_pkg;

    localparam int MFA_W     = 32;
    localparam int PF_EN_BIT = 3;
    localparam logic [MFA_W-1:0] EMPTY_MFA = '1;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_TAIL = 2'd2,
        SEL_CTRL = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PREF,
        ST_RESP
    } fsm_state_e;

    typedef struct packed {
        logic             valid;
        logic [MFA_W-1:0] mfa;
    } pf_entry_t;

endpackage

// File: rtl/mfq_ptr_regs.sv
module mfq_ptr_regs
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              tail_adv,
    output logic [ADDR_W-1:0] base_addr,
    output logic [OFF_W-1:0]  head_q,
    output logic [OFF_W-1:0]  tail_q,
    output logic              pf_en,
    output logic              empty,
    output logic              sw_inval
);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] STEP = OFF_W'(4);

    logic [BASE_W-1:0] base_hi;
    logic [OFF_W-1:0]  off_wr;
    cfg_sel_e          sel;
    logic              unused_lowbits;

    assign sel            = cfg_sel_e'(cfg_sel);
    assign off_wr         = {cfg_wdata[OFF_W-1:2], 2'b00};
    assign unused_lowbits = ^cfg_wdata[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            pf_en   <= 1'b0;
        end else begin
            if (cfg_we && sel == SEL_BASE) base_hi <= cfg_wdata[ADDR_W-1:OFF_W];
            if (cfg_we && sel == SEL_HEAD) head_q  <= off_wr;
            if (cfg_we && sel == SEL_CTRL) pf_en   <= cfg_wdata[PF_EN_BIT];
            if (cfg_we && sel == SEL_TAIL) tail_q  <= off_wr;
            else if (tail_adv)             tail_q  <= tail_q + STEP;
        end
    end

    assign base_addr = {base_hi, {OFF_W{1'b0}}};
    assign empty     = (head_q == tail_q);
    assign sw_inval  = cfg_we && (sel != SEL_CTRL || !cfg_wdata[PF_EN_BIT]);

endmodule

// File: rtl/mfq_prefetch_buf.sv
module mfq_prefetch_buf
    import mfq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic             load,
    input  logic [MFA_W-1:0] load_mfa,
    input  logic             consume,
    output logic             valid,
    output logic [MFA_W-1:0] mfa
);
    pf_entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (inval || consume) begin
            ent_q.valid <= 1'b0;
        end else if (load) begin
            ent_q.valid <= 1'b1;
            ent_q.mfa   <= load_mfa;
        end
    end

    assign valid = ent_q.valid;
    assign mfa   = ent_q.mfa;

endmodule

// File: rtl/mfq_ctrl_fsm.sv
module mfq_ctrl_fsm
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_valid,
    output logic              pop_ready,
    output logic [MFA_W-1:0]  pop_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [MFA_W-1:0]  mem_rdata,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  tail_q,
    input  logic              empty,
    input  logic              inval,
    input  logic              pf_valid,
    input  logic [MFA_W-1:0]  pf_mfa,
    output logic              pf_load,
    output logic              pf_consume,
    output logic              tail_adv
);
    fsm_state_e        state;
    logic [MFA_W-1:0]  resp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              kill_q;
    logic              pf_hit;
    logic              pf_good;
    logic [ADDR_W-1:0] fetch_addr;

    assign fetch_addr = base_addr | {{(ADDR_W-OFF_W){1'b0}}, tail_q};
    assign pf_hit     = pf_valid && !inval;
    assign pf_good    = (state == ST_PREF) && mem_rvalid && !kill_q && !inval;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            resp_q <= '0;
            addr_q <= '0;
            kill_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pop_valid) begin
                        if (empty) begin
                            resp_q <= EMPTY_MFA;
                            state  <= ST_RESP;
                        end else if (pf_hit) begin
                            resp_q <= pf_mfa;
                            state  <= ST_RESP;
                        end else begin
                            addr_q <= fetch_addr;
                            state  <= ST_FETCH;
                        end
                    end else if (!pf_valid && !inval) begin
                        addr_q <= fetch_addr;
                        kill_q <= 1'b0;
                        state  <= ST_PREF;
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        resp_q <= mem_rdata;
                        state  <= ST_RESP;
                    end
                end
                ST_PREF: begin
                    if (inval) kill_q <= 1'b1;
                    if (mem_rvalid) begin
                        if (pf_good && pop_valid) begin
                            resp_q <= mem_rdata;
                            state  <= ST_RESP;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pop_ready  = (state == ST_RESP);
    assign pop_data   = resp_q;
    assign mem_req    = (state == ST_FETCH) || (state == ST_PREF);
    assign mem_addr   = addr_q;
    assign pf_consume = (state == ST_IDLE) && pop_valid && !empty && pf_hit;
    assign pf_load    = pf_good && !pop_valid;
    assign tail_adv   = pf_consume
                     || ((state == ST_FETCH) && mem_rvalid)
                     || (pf_good && pop_valid);

endmodule

// File: rtl/mfq_freelist.sv
module mfq_freelist
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [OFF_W-1:0]  head_ptr,
    output logic [OFF_W-1:0]  tail_ptr,
    input  logic              pop_valid,
    output logic              pop_ready,
    output logic [31:0]       pop_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    logic [ADDR_W-1:0] base_addr;
    logic              pf_en, empty, sw_inval, inval;
    logic              tail_adv, pf_load, pf_consume, pf_valid;
    logic [MFA_W-1:0]  pf_mfa;

    assign inval = sw_inval || !pf_en || empty;

    mfq_ptr_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tail_adv(tail_adv), .base_addr(base_addr),
        .head_q(head_ptr), .tail_q(tail_ptr), .pf_en(pf_en),
        .empty(empty), .sw_inval(sw_inval)
    );

    mfq_prefetch_buf u_pf (
        .clk(clk), .rst(rst), .inval(inval), .load(pf_load),
        .load_mfa(mem_rdata), .consume(pf_consume),
        .valid(pf_valid), .mfa(pf_mfa)
    );

    mfq_ctrl_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk(clk), .rst(rst), .pop_valid(pop_valid), .pop_ready(pop_ready),
        .pop_data(pop_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .base_addr(base_addr), .tail_q(tail_ptr), .empty(empty),
        .inval(inval), .pf_valid(pf_valid), .pf_mfa(pf_mfa),
        .pf_load(pf_load), .pf_consume(pf_consume), .tail_adv(tail_adv)
    );

endmodule

// File: rtl/mfq_freelist_chk.sv
module mfq_freelist_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [OFF_W-1:0]  head_ptr,
    input logic [OFF_W-1:0]  tail_ptr,
    input logic              pop_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              pf_valid
);
    logic tail_sw;
    assign tail_sw = cfg_we && (cfg_sel == 2'd2);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pop_ready |=> !pop_ready);

    // R2
    no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(head_ptr != tail_ptr));

    // R5
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tail_sw) && tail_ptr != $past(tail_ptr))
            |-> (tail_ptr == $past(tail_ptr) + OFF_W'(4)));

    // R8
    pf_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (head_ptr != tail_ptr));

endmodule

bind mfq_freelist mfq_freelist_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .pop_ready(pop_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .pf_valid(pf_valid)
);

// File: tb/test_mfq_freelist.sv
module test_mfq_freelist;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam logic [31:0] BASE = 32'h0000_2000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic [OFF_W-1:0]  head_ptr, tail_ptr;
    logic              pop_valid = 1'b0;
    logic              pop_ready;
    logic [31:0]       pop_data;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;

    always #10 clk = ~clk;

    mfq_freelist #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_mfq_freelist (.*);

    int n_chk = 0, n_err = 0, n_reads = 0;
    logic done = 1'b0;
    logic [31:0] mem [4096];
    logic [31:0] exp_q [$];
    string       cur_tag;
    logic [31:0] last_addr = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // local memory model: 3-cycle read latency
    bit busy = 0;
    int cnt  = 0;
    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid = 1'b0; busy = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0; busy = 0;
        end else if (!busy && mem_req) begin
            busy = 1; cnt = 2; last_addr = mem_addr;
        end else if (busy) begin
            // R10: request held with stable address while outstanding
            check(mem_req && mem_addr == last_addr, "R10 held request", mem_addr, last_addr);
            cnt--;
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[int'(last_addr[13:2])];
                n_reads++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && pop_ready) begin
            if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected pop"}, pop_data, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(pop_data === e, cur_tag, pop_data, e);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic put(input logic [11:0] off, input logic [31:0] v);
        mem[int'((BASE | {20'd0, off}) >> 2) & 4095] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop(input logic [31:0] exp, input string tag, output int lat);
        cur_tag = tag;
        exp_q.push_back(exp);
        @(negedge clk); pop_valid = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!pop_ready && lat < 200);
        pop_valid = 1'b0;
        @(negedge clk);
        // R11: single-cycle completion pulse
        check(!pop_ready, "R11 ready pulse width", {31'd0, pop_ready}, 32'd0);
    endtask

    initial begin
        int lat, r0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(head_ptr == 0, "R1 head", 32'(head_ptr), 0);
        check(tail_ptr == 0, "R1 tail", 32'(tail_ptr), 0);
        check(!pop_ready, "R1 pop_ready", {31'd0, pop_ready}, 0);
        check(!mem_req, "R1 mem_req", {31'd0, mem_req}, 0);

        // R4 masking of writes
        wr(2'd1, 32'hABCD_E007);
        check(head_ptr == 12'h004, "R4 head mask", 32'(head_ptr), 32'h4);
        wr(2'd2, 32'h1234_5FFE);
        check(tail_ptr == 12'hFFC, "R4 tail mask", 32'(tail_ptr), 32'hFFC);
        wr(2'd2, 32'h0); wr(2'd1, 32'h0);
        wr(2'd0, 32'h0000_2ABC);

        // R2 empty pop
        r0 = n_reads;
        pop(32'hFFFF_FFFF, "R2 empty value", lat);
        check(lat == 1, "R2 empty latency", 32'(lat), 1);
        check(head_ptr == 0 && tail_ptr == 0, "R2 pointers kept", {head_ptr, 4'd0, tail_ptr}, 0);
        check(n_reads == r0, "R2 no read", 32'(n_reads), 32'(r0));

        // R3 demand fetches, prefetch off
        put(12'h000, 32'hA000_0100); put(12'h004, 32'hA000_0200); put(12'h008, 32'hA000_0300);
        wr(2'd1, 32'h00C);
        idle(8);
        check(n_reads == r0, "R3 no fetch without pop", 32'(n_reads), 32'(r0));
        pop(32'hA000_0100, "R3 pop 1", lat);
        check(last_addr == 32'h0000_2000, "R3 R4 fetch address", last_addr, 32'h2000);
        check(lat > 1, "R3 miss latency", 32'(lat), 2);
        pop(32'hA000_0200, "R3 pop 2", lat);
        pop(32'hA000_0300, "R3 pop 3", lat);
        check(last_addr == 32'h0000_2008, "R3 third address", last_addr, 32'h2008);
        check(tail_ptr == 12'h00C, "R3 tail advance", 32'(tail_ptr), 32'hC);
        check(n_reads == r0 + 3, "R3 read count", 32'(n_reads), 32'(r0 + 3));
        pop(32'hFFFF_FFFF, "R2 drained", lat);

        // R5 wraparound
        wr(2'd2, 32'hFF8); wr(2'd1, 32'hFF8);
        put(12'hFF8, 32'hB000_0001); put(12'hFFC, 32'hB000_0002); put(12'h000, 32'hB000_0003);
        wr(2'd1, 32'h004);
        pop(32'hB000_0001, "R5 pop a", lat);
        pop(32'hB000_0002, "R5 pop b", lat);
        check(tail_ptr == 12'h000, "R5 tail wrap", 32'(tail_ptr), 0);
        pop(32'hB000_0003, "R5 pop c", lat);
        check(tail_ptr == 12'h004, "R5 tail after wrap", 32'(tail_ptr), 4);

        // R9 prefetch on head write into empty list
        wr(2'd3, 32'h8);
        idle(8);
        r0 = n_reads;
        put(12'h004, 32'hC000_0004);
        wr(2'd1, 32'h008);
        idle(10);
        check(n_reads == r0 + 1, "R9 prefetch started", 32'(n_reads), 32'(r0 + 1));
        pop(32'hC000_0004, "R7 hit value", lat);
        check(lat == 1, "R7 hit latency", 32'(lat), 1);
        idle(10);
        check(n_reads == r0 + 1, "R7 no read on hit", 32'(n_reads), 32'(r0 + 1));

        // R6 chained prefetch
        put(12'h008, 32'hD000_0008); put(12'h00C, 32'hD000_000C); put(12'h010, 32'hD000_0010);
        wr(2'd1, 32'h014);
        idle(10);
        pop(32'hD000_0008, "R7 hit E", lat);
        check(lat == 1, "R7 hit E latency", 32'(lat), 1);
        idle(10);
        check(n_reads == r0 + 3, "R6 next prefetched", 32'(n_reads), 32'(r0 + 3));
        pop(32'hD000_000C, "R6 hit F", lat);
        check(lat == 1, "R6 hit F latency", 32'(lat), 1);
        idle(10);
        check(tail_ptr == 12'h010, "R7 tail advance", 32'(tail_ptr), 32'h10);

        // R8 head rewrite discards stale word
        put(12'h010, 32'hE000_0010);
        wr(2'd1, 32'h014);
        idle(10);
        pop(32'hE000_0010, "R8 refreshed after head write", lat);
        check(lat == 1, "R8 refetched into prefetch", 32'(lat), 1);

        // R8 disabling prefetch discards stale word
        put(12'h014, 32'hF000_0014);
        wr(2'd1, 32'h018);
        idle(10);
        put(12'h014, 32'hF000_0099);
        wr(2'd3, 32'h0);
        pop(32'hF000_0099, "R8 fresh after disable", lat);
        check(lat > 1, "R8 disabled means demand fetch", 32'(lat), 2);
        check(tail_ptr == 12'h018, "R8 tail", 32'(tail_ptr), 32'h18);

        idle(4);
        check(exp_q.size() == 0, "R11 all pops answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
            $finish;
        end
    end

endmodule